// File: doc/BRIEF.md
# Two-Point Oscillator Trim Calibrator

This block works out a 4-bit oscillator trim code for a device under test from two timing measurements. The device is first run with its trim at -8, its fastest setting, and then at +7, its slowest. At each setting it sends a stream of pulses back on `pulse_in`. The block times a power-of-two number of time elements at each setting. A time element is the span between two consecutive transitions. It averages each set of elements with a shift and keeps the two averaged periods.

Once both settings have been measured, the block interpolates linearly between the two frequencies to find the trim that gives the target period. The work is done on periods rather than frequencies, so no reciprocal is ever formed. The only division is done by a short sequential divider. The result is saturated and written in the device's offset trim encoding.

The intended use is to run one measurement per trim setting, each started by the controller. Transitions that arrive after the last timed element, such as a header gap after a preamble, are ignored. A measurement that sees no transitions ends in a timeout flag.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, both stored periods are 0, `trim_code` is 0, and `busy`, `done`, `err_order` and `err_timeout` are all low.
- R2: A time element is the number of clock cycles between two consecutive transitions of `pulse_in`, of either polarity. The first transition after a measurement starts only begins the timing.
- R3: A measurement ends after 2^LOG2_AVG elements. The stored period is floor(sum of elements / 2^LOG2_AVG). It goes to `period_hi` when `meas_point` was 0 at the start (trim -8) and to `period_lo` when it was 1 (trim +7).
- R4: Transitions and gaps after the last timed element change no stored period and raise no timeout, even if a gap is longer than TIMEOUT_CYC.
- R5: If a measurement sees no transition for TIMEOUT_CYC cycles, `err_timeout` goes high, `busy` drops, and both stored periods stay unchanged.
- R6: A `meas_start` pulse that arrives while `busy` is high is ignored. The running measurement keeps the point it was started with.
- R7: When both points have been measured since reset and `period_hi >= period_lo`, `err_order` goes high, `done` stays low, and `trim_code` keeps its previous value.
- R8: Let Ph be `period_hi`, Pl be `period_lo` and Pt be `target_period`. When Ph < Pt < Pl, the index is v = floor(16·Ph·(Pl−Pt) / (Pt·(Pl−Ph))). The signed trim is 7−v, and `trim_code` is its bitwise inverse, which equals v XOR 0x8. So -8 is written as 0x7 and +7 as 0x8.
- R9: Saturation: if Pt >= Pl (with Ph < Pl), `trim_code` is 0x8 (+7). If Pt <= Ph, `trim_code` is 0x7 (-8).
- R10: The calculation starts by itself when a measurement finishes and both points have been measured since reset. `target_period` is sampled at that moment. `done` is then set, and it is cleared by the next accepted `meas_start`, as are both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Calibration pulse stream from the device (asynchronous) |
| meas_start | input | 1 | Start a measurement (one-cycle pulse) |
| meas_point | input | 1 | Measurement point: 0 = trim -8, 1 = trim +7 |
| target_period | input | PW | Desired time element, in clock cycles |
| period_hi | output | PW | Averaged period at trim -8 |
| period_lo | output | PW | Averaged period at trim +7 |
| trim_code | output | 4 | Resulting trim in offset encoding |
| busy | output | 1 | Measurement or calculation in progress |
| done | output | 1 | A valid trim code is present |
| err_order | output | 1 | The -8 point was not faster than the +7 point |
| err_timeout | output | 1 | No transition within TIMEOUT_CYC cycles |

## Verification
The bench builds the block with PW=12, LOG2_AVG=2 and TIMEOUT_CYC=600. Four elements per point keep each measurement short. Uneven element widths then exercise the floor in the averaging shift. The short timeout makes the no-signal case cheap to reach. It also means a header gap of 900 cycles is longer than the timeout, which shows that the gap after the last timed element is ignored. At these widths the interpolation products stay small, so the bench can work out the trim index exactly, including one case where the divider lands on a whole index.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

  localparam int TRIM_W = 4;

  // Index 0 is the slowest trim (+7); the largest index is the fastest (-8).
  function automatic logic [TRIM_W-1:0] trim_signed(input logic [TRIM_W-1:0] idx);
    return TRIM_W'((1 << (TRIM_W-1)) - 1) - idx;
  endfunction

  // The device writes a signed trim as its bitwise inverse.
  function automatic logic [TRIM_W-1:0] trim_encode(input logic [TRIM_W-1:0] s);
    return ~s;
  endfunction

  function automatic logic [TRIM_W-1:0] index_to_code(input logic [TRIM_W-1:0] idx);
    return trim_encode(trim_signed(idx));
  endfunction

  localparam logic [TRIM_W-1:0] IDX_MAX = {TRIM_W{1'b1}};

endpackage

// File: rtl/cal_elem_timer.sv
module cal_elem_timer #(
  parameter int PW          = 16,
  parameter int LOG2_AVG    = 3,
  parameter int TIMEOUT_CYC = 60000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          edge_in,
  output logic          done_p,
  output logic          timeout_p,
  output logic [PW-1:0] avg
);
  localparam int NEL = 1 << LOG2_AVG;
  localparam int NW  = $clog2(NEL + 1);
  localparam int SW  = PW + LOG2_AVG;
  localparam logic [PW-1:0] TO_LAST = PW'(TIMEOUT_CYC - 1);
  localparam logic [NW-1:0] EL_LAST = NW'(NEL - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} tstate_t;
  tstate_t st;

  logic [PW-1:0] cnt;
  logic [NW-1:0] nel;
  logic [SW-1:0] sum;
  logic [SW-1:0] sum_nx;
  logic          last_el;
  logic          gap_expired;

  assign sum_nx      = sum + SW'(cnt) + SW'(1);
  assign last_el     = (nel == EL_LAST);
  assign gap_expired = (cnt == TO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      nel       <= '0;
      sum       <= '0;
      avg       <= '0;
      done_p    <= 1'b0;
      timeout_p <= 1'b0;
    end else begin
      done_p    <= 1'b0;
      timeout_p <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st  <= S_ARM;
            cnt <= '0;
            nel <= '0;
            sum <= '0;
          end
        end
        S_ARM: begin
          if (edge_in) begin
            st  <= S_RUN;
            cnt <= '0;
          end else if (gap_expired) begin
            timeout_p <= 1'b1;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + PW'(1);
          end
        end
        S_RUN: begin
          if (edge_in) begin
            cnt <= '0;
            sum <= sum_nx;
            nel <= nel + NW'(1);
            if (last_el) begin
              avg    <= sum_nx[SW-1:LOG2_AVG];
              done_p <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (gap_expired) begin
            timeout_p <= 1'b1;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + PW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a measurement ends either by completing or by timing out, never both
  a_r5_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_p, timeout_p}));

  // R3: completion only follows a transition seen on the element input
  a_r3_done_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |-> $past(edge_in));

endmodule

// File: rtl/cal_frac_div.sv
module cal_frac_div #(
  parameter int DW = 32,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          run,
  output logic          fin,
  output logic [QW-1:0] quo
);
  localparam int CW = $clog2(QW + 1);

  logic [DW:0]   rem;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt;
  logic [DW:0]   rem_sh;
  logic          take;

  assign rem_sh = {rem[DW-1:0], 1'b0};
  assign take   = (rem_sh >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
      quo   <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem   <= {1'b0, num};
        den_q <= den;
        cnt   <= CW'(QW);
        run   <= 1'b1;
        quo   <= '0;
      end else if (run) begin
        rem <= take ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo <= {quo[QW-2:0], take};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R8: the caller only hands over fractions below one, so the remainder stays below the divisor
  a_r8_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem < {1'b0, den_q}));

  // R8: a new division is never launched over a running one
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_cal_pkg::*;
#(
  parameter int PW          = 16,
  parameter int LOG2_AVG    = 3,
  parameter int TIMEOUT_CYC = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_in,
  input  logic              meas_start,
  input  logic              meas_point,
  input  logic [PW-1:0]     target_period,
  output logic [PW-1:0]     period_hi,
  output logic [PW-1:0]     period_lo,
  output logic [TRIM_W-1:0] trim_code,
  output logic              busy,
  output logic              done,
  output logic              err_order,
  output logic              err_timeout
);
  localparam int DW = 2 * PW;

  typedef enum logic [1:0] {T_IDLE, T_MEAS, T_CHK, T_DIV} cstate_t;
  cstate_t st;

  logic [2:0]  sync_q;
  wire         pulse_edge = sync_q[2] ^ sync_q[1];

  logic          pt_q, hv_q, lv_q;
  logic [PW-1:0] ph_q, pl_q;
  logic [TRIM_W-1:0] code_q;
  logic          done_q, eo_q, et_q;

  wire start_acc = meas_start && (st == T_IDLE);

  logic          tm_done, tm_to;
  logic [PW-1:0] tm_avg;

  logic          div_run, div_fin;
  logic [TRIM_W-1:0] div_quo;
  wire  order_bad = (ph_q >= pl_q);
  wire  tgt_slow  = (target_period >= pl_q);
  wire  tgt_fast  = (target_period <= ph_q);
  wire  div_start = (st == T_CHK) && !order_bad && !tgt_slow && !tgt_fast;
  logic [DW-1:0] div_num, div_den;

  assign div_num = DW'(ph_q) * DW'(pl_q - target_period);
  assign div_den = DW'(target_period) * DW'(pl_q - ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pulse_in};
  end

  cal_elem_timer #(
    .PW(PW), .LOG2_AVG(LOG2_AVG), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_acc), .edge_in(pulse_edge),
    .done_p(tm_done), .timeout_p(tm_to), .avg(tm_avg)
  );

  cal_frac_div #(.DW(DW), .QW(TRIM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .run(div_run), .fin(div_fin), .quo(div_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      pt_q   <= 1'b0;
      hv_q   <= 1'b0;
      lv_q   <= 1'b0;
      ph_q   <= '0;
      pl_q   <= '0;
      code_q <= '0;
      done_q <= 1'b0;
      eo_q   <= 1'b0;
      et_q   <= 1'b0;
    end else begin
      case (st)
        T_IDLE: begin
          if (start_acc) begin
            st     <= T_MEAS;
            pt_q   <= meas_point;
            done_q <= 1'b0;
            eo_q   <= 1'b0;
            et_q   <= 1'b0;
          end
        end
        T_MEAS: begin
          if (tm_to) begin
            et_q <= 1'b1;
            st   <= T_IDLE;
          end else if (tm_done) begin
            if (pt_q) begin
              pl_q <= tm_avg;
              lv_q <= 1'b1;
            end else begin
              ph_q <= tm_avg;
              hv_q <= 1'b1;
            end
            st <= (pt_q ? hv_q : lv_q) ? T_CHK : T_IDLE;
          end
        end
        T_CHK: begin
          if (order_bad) begin
            eo_q <= 1'b1;
            st   <= T_IDLE;
          end else if (tgt_slow) begin
            code_q <= index_to_code('0);
            done_q <= 1'b1;
            st     <= T_IDLE;
          end else if (tgt_fast) begin
            code_q <= index_to_code(IDX_MAX);
            done_q <= 1'b1;
            st     <= T_IDLE;
          end else begin
            st <= T_DIV;
          end
        end
        T_DIV: begin
          if (div_fin) begin
            code_q <= index_to_code(div_quo);
            done_q <= 1'b1;
            st     <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign period_hi   = ph_q;
  assign period_lo   = pl_q;
  assign trim_code   = code_q;
  assign busy        = (st != T_IDLE);
  assign done        = done_q;
  assign err_order   = eo_q;
  assign err_timeout = et_q;

  // R7: an order error never comes with a valid code
  a_r7_no_done_with_order_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_order));

  // R10: a code only appears once the -8 point is faster than the +7 point
  a_r10_done_needs_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (period_hi < period_lo));

  // R5: a timeout leaves both stored periods as they were
  a_r5_timeout_keeps_periods: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> ($stable(period_hi) && $stable(period_lo)));

  // R7: the code only moves while the block is busy
  a_r7_code_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(trim_code));

  // R8: the divider only runs during the calculation step
  a_r8_div_in_calc: assert property (@(posedge clk) disable iff (!rst_n)
    div_run |-> busy);

endmodule

// File: tb/tb_osc_trim_cal.sv
module tb_osc_trim_cal;
  localparam int PW = 12;
  localparam int LA = 2;
  localparam int TO = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic meas_start = 1'b0;
  logic meas_point = 1'b0;
  logic [PW-1:0] target_period = '0;
  logic [PW-1:0] period_hi, period_lo;
  logic [3:0] trim_code;
  logic busy, done, err_order, err_timeout;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  osc_trim_cal #(.PW(PW), .LOG2_AVG(LA), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .meas_start(meas_start),
    .meas_point(meas_point), .target_period(target_period),
    .period_hi(period_hi), .period_lo(period_lo), .trim_code(trim_code),
    .busy(busy), .done(done), .err_order(err_order), .err_timeout(err_timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent model of the interpolated code
  function automatic int exp_code(input int ph, input int pl, input int pt);
    int v;
    if (pt >= pl) return 8;
    if (pt <= ph) return 7;
    v = (16 * ph * (pl - pt)) / (pt * (pl - ph));
    return v ^ 8;
  endfunction

  task automatic start_meas(input logic pt);
    @(negedge clk);
    meas_start = 1'b1;
    meas_point = pt;
    @(negedge clk);
    meas_start = 1'b0;
  endtask

  task automatic toggle_wait(input int w);
    pulse_in = ~pulse_in;
    repeat (w) @(negedge clk);
  endtask

  task automatic train(input int w0, input int w1, input int w2, input int w3, input int gap);
    repeat (4) @(negedge clk);
    toggle_wait(w0);
    toggle_wait(w1);
    toggle_wait(w2);
    toggle_wait(w3);
    toggle_wait(gap);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(input logic pt, input int w0, input int w1, input int w2,
                         input int w3, input int gap);
    start_meas(pt);
    train(w0, w1, w2, w3, gap);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 period_hi", int'(period_hi), 0);
    chk("R1 period_lo", int'(period_lo), 0);
    chk("R1 trim_code", int'(trim_code), 0);
    chk("R1 flags", int'({busy, done, err_order, err_timeout}), 0);
  endtask

  task automatic t_first_point();
    measure(1'b0, 20, 20, 20, 20, 10);
    chk("R2 R3 period_hi", int'(period_hi), 20);
    chk("R10 no calc with one point", int'(done), 0);
    chk("R10 code untouched", int'(trim_code), 0);
  endtask

  task automatic t_interp(input int tgt, input int expc, input string tag);
    target_period = PW'(tgt);
    measure(1'b1, 40, 44, 40, 43, 10);
    chk("R3 floor average", int'(period_lo), 41);
    chk({tag, " code"}, int'(trim_code), expc);
    chk("R10 done", int'(done), 1);
  endtask

  task automatic t_header_gap();
    target_period = PW'(25);
    start_meas(1'b1);
    train(41, 41, 41, 41, 5);
    toggle_wait(5);
    toggle_wait(900);
    wait_idle();
    chk("R4 no timeout on gap", int'(err_timeout), 0);
    chk("R4 period_lo kept", int'(period_lo), 41);
    chk("R8 code after gap", int'(trim_code), exp_code(20, 41, 25));
  endtask

  task automatic t_busy_ignore();
    target_period = PW'(30);
    start_meas(1'b1);
    chk("R6 busy", int'(busy), 1);
    start_meas(1'b0);
    train(36, 36, 36, 36, 10);
    wait_idle();
    chk("R6 period_lo from first start", int'(period_lo), 36);
    chk("R6 period_hi untouched", int'(period_hi), 20);
    chk("R8 code", int'(trim_code), 12);
  endtask

  task automatic t_timeout();
    start_meas(1'b0);
    wait_idle();
    chk("R5 err_timeout", int'(err_timeout), 1);
    chk("R5 period_hi kept", int'(period_hi), 20);
    chk("R10 done cleared", int'(done), 0);
    chk("R5 busy dropped", int'(busy), 0);
  endtask

  task automatic t_order();
    measure(1'b0, 50, 50, 50, 50, 10);
    chk("R7 err_order", int'(err_order), 1);
    chk("R7 done low", int'(done), 0);
    chk("R7 code kept", int'(trim_code), 12);
    chk("R5 timeout flag cleared", int'(err_timeout), 0);
  endtask

  task automatic t_exact();
    target_period = PW'(24);
    measure(1'b0, 12, 12, 12, 12, 10);
    chk("R8 code at Ph=12 Pl=36", int'(trim_code), exp_code(12, 36, 24));
    chk("R7 order cleared", int'(err_order), 0);
    measure(1'b1, 60, 60, 60, 60, 10);
    chk("R8 exact index", int'(trim_code), 14);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_point();
    t_interp(30, exp_code(20, 41, 30), "R8");
    t_header_gap();
    t_interp(50, 8, "R9 slow sat");
    t_interp(15, 7, "R9 fast sat");
    t_busy_ignore();
    t_timeout();
    t_order();
    t_exact();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule